// File: doc/BRIEF.md
# Timer Channel Status Flag Register

This block is one timer channel: a counter that steps up or down by one, and an 8-bit status byte that reports what the counter has done. The status byte shows the current count direction. It also holds two sticky event flags. One records that the counter wrapped from all-ones to zero. The other records that it wrapped from zero to all-ones.

Software reads the byte through a simple register port. A read returns the byte one cycle later. To clear a flag, software must first read the byte and see that flag set, then write zero to that flag's bit position. Any other write leaves the flag as it is.

A parameter marks the channel as able or unable to do phase counting. A channel without phase counting always counts up. On such a channel the direction bit is fixed at 1 and the underflow bit is fixed at 0.

Top module: `tmr_stat_chan`

## Requirements
- R1: After reset the counter is zero, and a read returns the status byte 0xC0.
- R2: At each clock edge with `cnt_en` high, the counter moves by one: up when `dir_up` is 1, down when `dir_up` is 0. With `cnt_en` low, the counter holds its value.
- R3: Bit 4 (overflow flag) becomes 1 when an enabled step takes the counter from all-ones to zero. It then stays 1 until it is cleared.
- R4: On a phase-counting channel, bit 5 (underflow flag) becomes 1 when an enabled step takes the counter from zero to all-ones. It then stays 1 until it is cleared.
- R5: Bit 6 always reads 1 and bits 3..0 always read 0, whatever is written. On a phase-counting channel, bit 7 reads the direction applied at the previous edge (1 = up, 0 = down).
- R6: A write with 0 in a flag's bit position clears that flag, provided an earlier read returned that flag as 1 and no write has happened since that read.
- R7: Writing 1 to a flag bit leaves the flag unchanged. Writing 0 with no qualifying earlier read also leaves the flag unchanged.
- R8: Any write cancels the permission that a read granted, so a second zero-write needs a fresh read before it can clear a flag.
- R9: When a flag's set event and a valid clear fall in the same cycle, the flag stays 1.
- R10: On a channel without phase counting, the counter steps up whatever `dir_up` is, bit 7 reads 1 and bit 5 reads 0.
- R11: `rd_vld` is high in the cycle after a read request, and `rd_data` holds the byte as it was before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_en | input | 1 | Step the counter this cycle |
| dir_up | input | 1 | Step direction: 1 = up, 0 = down (phase-counting channels only) |
| rd_en | input | 1 | Read the status byte |
| wr_en | input | 1 | Write the status byte |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Registered read data |
| rd_vld | output | 1 | `rd_data` is valid this cycle |
| count | output | CNT_W | Current counter value |

## Verification
The bench builds two instances of the block.

- The first uses the default 16-bit counter with phase counting enabled. Both wraps are reachable in a handful of steps from zero: one step down gives the underflow, and one step back up gives the overflow. This lets the bench cover the full read-then-clear handshake, disarming by a write, and a set event colliding with a clear.
- The second disables phase counting and uses an 8-bit counter. An overflow is reached after 256 up-steps while `dir_up` is held at 0, which shows that the direction input and the direction-dependent bits have no effect on this channel type.

// File: rtl/tmr_stat_pkg.sv
package tmr_stat_pkg;
  localparam int unsigned STAT_W  = 8;
  localparam int unsigned BIT_DIR = 7;
  localparam int unsigned BIT_RSV = 6;
  localparam int unsigned BIT_UNF = 5;
  localparam int unsigned BIT_OVF = 4;
  localparam logic [STAT_W-1:0] STAT_RST = 8'hC0;

  typedef struct packed {
    logic dir_up;
    logic unf;
    logic ovf;
  } stat_t;

  function automatic logic [STAT_W-1:0] pack_stat(input stat_t s);
    logic [STAT_W-1:0] b;
    b          = '0;
    b[BIT_DIR] = s.dir_up;
    b[BIT_RSV] = 1'b1;
    b[BIT_UNF] = s.unf;
    b[BIT_OVF] = s.ovf;
    return b;
  endfunction
endpackage

// File: rtl/tmr_updown_cnt.sv
module tmr_updown_cnt #(
  parameter int unsigned CNT_W    = 16,
  parameter bit          PHASE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             dir_up,
  output logic [CNT_W-1:0] count,
  output logic             dir_q,
  output logic             ovf_ev,
  output logic             unf_ev
);
  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
  localparam logic [CNT_W-1:0] CNT_ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic up_eff;
  logic [CNT_W-1:0] cnt_q;

  generate
    if (PHASE_EN) begin : g_dir
      assign up_eff = dir_up;
    end else begin : g_fixed_up
      assign up_eff = 1'b1;
    end
  endgenerate

  assign ovf_ev = cnt_en &  up_eff & (cnt_q == CNT_MAX);
  assign unf_ev = cnt_en & ~up_eff & (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      dir_q <= 1'b1;
    end else begin
      dir_q <= up_eff;
      if (cnt_en) begin
        if (up_eff) cnt_q <= cnt_q + CNT_ONE;
        else        cnt_q <= cnt_q - CNT_ONE;
      end
    end
  end

  assign count = cnt_q;

  p_step_up_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && up_eff) |=> (cnt_q == $past(cnt_q) + CNT_ONE));
  p_step_dn_r2: assert property (@(posedge clk) disable iff (rst)
    (cnt_en && !up_eff) |=> (cnt_q == $past(cnt_q) - CNT_ONE));
  p_hold_r2: assert property (@(posedge clk) disable iff (rst)
    !cnt_en |=> $stable(cnt_q));
  p_ovf_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> (cnt_q == '0));
  p_unf_wrap_r4: assert property (@(posedge clk) disable iff (rst)
    unf_ev |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/tmr_sticky_flag.sv
module tmr_sticky_flag (
  input  logic clk,
  input  logic rst,
  input  logic set_ev,
  input  logic rd_en,
  input  logic wr_en,
  input  logic wr_bit,
  output logic flag
);
  logic flag_q;
  logic arm_q;
  logic clr;

  assign clr = wr_en & ~wr_bit & arm_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      flag_q <= 1'b0;
      arm_q  <= 1'b0;
    end else begin
      if (set_ev)   flag_q <= 1'b1;
      else if (clr) flag_q <= 1'b0;
      if (rd_en && flag_q) arm_q <= 1'b1;
      else if (wr_en)      arm_q <= 1'b0;
    end
  end

  assign flag = flag_q;

  p_set_wins_r9: assert property (@(posedge clk) disable iff (rst)
    set_ev |=> flag_q);
  p_unarmed_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && !arm_q) |=> flag_q);
  p_wr_one_keep_r7: assert property (@(posedge clk) disable iff (rst)
    (flag_q && wr_en && wr_bit) |=> flag_q);
  p_clear_r6: assert property (@(posedge clk) disable iff (rst)
    (arm_q && wr_en && !wr_bit && !set_ev) |=> !flag_q);
  p_disarm_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_en && !rd_en) |=> !arm_q);
endmodule

// File: rtl/tmr_stat_rdport.sv
module tmr_stat_rdport
  import tmr_stat_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              rd_en,
  input  stat_t             stat,
  output logic [STAT_W-1:0] rd_data,
  output logic              rd_vld
);
  always_ff @(posedge clk) begin
    if (rst) begin
      rd_data <= STAT_RST;
      rd_vld  <= 1'b0;
    end else begin
      rd_vld <= rd_en;
      if (rd_en) rd_data <= pack_stat(stat);
    end
  end

  p_fixed_bits_r5: assert property (@(posedge clk) disable iff (rst)
    rd_vld |-> (rd_data[BIT_RSV] && rd_data[3:0] == 4'h0));
  p_vld_follows_r11: assert property (@(posedge clk) disable iff (rst)
    rd_en |=> rd_vld);
  p_data_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/tmr_stat_chan.sv
module tmr_stat_chan
  import tmr_stat_pkg::*;
#(
  parameter int unsigned CNT_W    = 16,
  parameter bit          PHASE_EN = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_en,
  input  logic             dir_up,
  input  logic             rd_en,
  input  logic             wr_en,
  input  logic [7:0]       wr_data,
  output logic [7:0]       rd_data,
  output logic             rd_vld,
  output logic [CNT_W-1:0] count
);
  logic  dir_q, ovf_ev, unf_ev;
  logic  ovf_flag, unf_flag;
  stat_t stat;

  tmr_updown_cnt #(.CNT_W(CNT_W), .PHASE_EN(PHASE_EN)) u_cnt (
    .clk(clk), .rst(rst), .cnt_en(cnt_en), .dir_up(dir_up),
    .count(count), .dir_q(dir_q), .ovf_ev(ovf_ev), .unf_ev(unf_ev)
  );

  tmr_sticky_flag u_ovf (
    .clk(clk), .rst(rst), .set_ev(ovf_ev), .rd_en(rd_en),
    .wr_en(wr_en), .wr_bit(wr_data[BIT_OVF]), .flag(ovf_flag)
  );

  generate
    if (PHASE_EN) begin : g_unf
      tmr_sticky_flag u_unf (
        .clk(clk), .rst(rst), .set_ev(unf_ev), .rd_en(rd_en),
        .wr_en(wr_en), .wr_bit(wr_data[BIT_UNF]), .flag(unf_flag)
      );
      assign stat.dir_up = dir_q;
      assign stat.unf    = unf_flag;
    end else begin : g_no_unf
      assign unf_flag    = 1'b0;
      assign stat.dir_up = 1'b1;
      assign stat.unf    = 1'b0;
    end
  endgenerate

  assign stat.ovf = ovf_flag;

  tmr_stat_rdport u_rd (
    .clk(clk), .rst(rst), .rd_en(rd_en), .stat(stat),
    .rd_data(rd_data), .rd_vld(rd_vld)
  );

  p_np_fixed_r10: assert property (@(posedge clk) disable iff (rst)
    (!PHASE_EN && rd_vld) |-> (rd_data[BIT_DIR] && !rd_data[BIT_UNF]));
  p_ovf_sets_r3: assert property (@(posedge clk) disable iff (rst)
    ovf_ev |=> ovf_flag);
  p_unf_sets_r4: assert property (@(posedge clk) disable iff (rst)
    (PHASE_EN && unf_ev) |=> unf_flag);
endmodule

// File: tb/tmr_stat_chan_tb.sv
module tmr_stat_chan_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WA = 16;
  localparam int WB = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sel = 1'b0;
  logic cnt_en = 1'b0, dir_up = 1'b1, rd_en = 1'b0, wr_en = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic [7:0] rd_a, rd_b;
  logic vld_a, vld_b;
  logic [WA-1:0] cnt_a;
  logic [WB-1:0] cnt_b;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] q_a[$];
  logic [7:0] q_b[$];
  string t_a[$];
  string t_b[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  tmr_stat_chan #(.CNT_W(WA), .PHASE_EN(1'b1)) u_dut (
    .clk(clk), .rst(rst), .cnt_en(cnt_en & ~sel), .dir_up(dir_up),
    .rd_en(rd_en & ~sel), .wr_en(wr_en & ~sel), .wr_data(wr_data),
    .rd_data(rd_a), .rd_vld(vld_a), .count(cnt_a)
  );

  tmr_stat_chan #(.CNT_W(WB), .PHASE_EN(1'b0)) u_dut_np (
    .clk(clk), .rst(rst), .cnt_en(cnt_en & sel), .dir_up(dir_up),
    .rd_en(rd_en & sel), .wr_en(wr_en & sel), .wr_data(wr_data),
    .rd_data(rd_b), .rd_vld(vld_b), .count(cnt_b)
  );

  // Monitor: pop expected bytes as read results appear
  always @(negedge clk) begin
    if (!rst && vld_a) begin
      n_chk++;
      if (q_a.size() == 0) begin
        n_fail++; $display("FAIL R11 unexpected read on phase channel: got %h expected none", rd_a);
      end else begin
        logic [7:0] e; string t;
        e = q_a.pop_front(); t = t_a.pop_front();
        if (rd_a !== e) begin
          n_fail++; $display("FAIL %s phase channel: got %h expected %h", t, rd_a, e);
        end
      end
    end
    if (!rst && vld_b) begin
      n_chk++;
      if (q_b.size() == 0) begin
        n_fail++; $display("FAIL R11 unexpected read on fixed channel: got %h expected none", rd_b);
      end else begin
        logic [7:0] e; string t;
        e = q_b.pop_front(); t = t_b.pop_front();
        if (rd_b !== e) begin
          n_fail++; $display("FAIL %s fixed channel: got %h expected %h", t, rd_b, e);
        end
      end
    end
  end

  task automatic rd(input logic [7:0] exp, input string tag);
    rd_en = 1'b1;
    if (sel) begin q_b.push_back(exp); t_b.push_back(tag); end
    else     begin q_a.push_back(exp); t_a.push_back(tag); end
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input int n, input logic up);
    dir_up = up; cnt_en = 1'b1;
    repeat (n) @(negedge clk);
    cnt_en = 1'b0;
  endtask

  task automatic chk_cnt(input int got, input int exp, input string tag);
    n_chk++;
    if (got != exp) begin
      n_fail++; $display("FAIL %s count: got %h expected %h", tag, got, exp);
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired: got hang expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // ---- phase-counting channel ----
    chk_cnt(cnt_a, 0, "R1");
    rd(8'hC0, "R1");
    step(3, 1'b1);                  chk_cnt(cnt_a, 3, "R2 up");
    repeat (2) @(negedge clk);      chk_cnt(cnt_a, 3, "R2 hold");
    step(3, 1'b0);                  chk_cnt(cnt_a, 0, "R2 down");
    rd(8'h40, "R5 dir down");
    step(1, 1'b0);                  chk_cnt(cnt_a, 16'hFFFF, "R4 wrap");
    rd(8'h60, "R4");
    wr(8'h00);
    rd(8'h40, "R6 clear unf");
    step(1, 1'b1);                  chk_cnt(cnt_a, 0, "R3 wrap");
    wr(8'h00);                      // no prior read: no effect
    rd(8'hD0, "R7 unread zero-write");
    wr(8'hFF);                      // write 1: no effect, disarms
    rd(8'hD0, "R7 write one");      // rearms
    wr(8'hFF);
    wr(8'h00);                      // disarmed by previous write
    rd(8'hD0, "R8 disarm");
    wr(8'h00);
    rd(8'hC0, "R6 clear ovf");
    step(1, 1'b0);
    step(1, 1'b1);                  chk_cnt(cnt_a, 0, "R2 back");
    rd(8'hF0, "R5 both flags");
    dir_up = 1'b0; cnt_en = 1'b1; wr_en = 1'b1; wr_data = 8'h00;
    @(negedge clk);
    cnt_en = 1'b0; wr_en = 1'b0;
    chk_cnt(cnt_a, 16'hFFFF, "R9 step");
    rd(8'h60, "R9 set beats clear");
    wr(8'h00);
    rd(8'h40, "R6 final");
    // ---- fixed-direction channel ----
    sel = 1'b1;
    @(negedge clk);
    rd(8'hC0, "R1 fixed");
    step(5, 1'b0);                  chk_cnt(cnt_b, 5, "R10 counts up");
    rd(8'hC0, "R10 dir bit");
    step(251, 1'b0);                chk_cnt(cnt_b, 0, "R10 wrap");
    rd(8'hD0, "R3 fixed");
    wr(8'h00);
    rd(8'hC0, "R6 fixed");
    repeat (3) @(negedge clk);
    if (q_a.size() != 0 || q_b.size() != 0) begin
      n_chk++; n_fail++;
      $display("FAIL R11 missing reads: got %0d pending expected 0", q_a.size() + q_b.size());
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule